// File: doc/BRIEF.md
# Accumulator Logical Operation Unit

This block carries out the byte-wide logical instructions of a small 8-bit accumulator machine: AND, exclusive-OR and inclusive-OR. It decodes the opcode and picks the second operand. That operand is one of six general registers, the accumulator itself, the immediate byte that follows the opcode, or a memory byte addressed by the H:L register pair. It then forms the result and the five condition flags and presents them on a write strobe for the accumulator and flag registers that sit outside the block.

With each write it also reports the machine-cycle and clock-state cost of the instruction. Register and immediate forms finish in the cycle after the start pulse. The memory form raises a read request and waits for the memory to return valid data. An opcode outside the three logical groups produces only an "unhandled" pulse.

Top module: `acc_logic_unit`

## Requirements
- R1: On `wr_en`, `acc_out` equals the accumulator AND, XOR or OR the operand. Opcode bits [5:3] select the operation: 100 AND, 101 XOR, 110 OR.
- R2: The flags are packed in `flags_out` as {sign[4], zero[3], aux[2], parity[1], carry[0]}. Zero is set when the result is 0x00. Sign copies result bit 7. Parity is set for an even number of one bits.
- R3: The carry flag is 0 after every logical instruction.
- R4: For AND, aux equals the OR of bit 3 of both operands when `AND_AC_BIT3`=1, and is forced to 1 when `AND_AC_BIT3`=0.
- R5: XOR and OR clear the aux flag.
- R6: Register form is opcode 10ooosss with sss≠110. For sss 0..5 the operand is byte sss of `regs_flat` (B,C,D,E,H,L at bits [8s+7:8s]), and sss=111 selects the accumulator. `wr_en` pulses one cycle after `start` with `m_cycles`=1 and `t_states`=4.
- R7: Immediate form is opcode 11ooo110 (0xE6 AND, 0xEE XOR, 0xF6 OR) and uses `imm_in`. `wr_en` pulses one cycle after `start` with `m_cycles`=2 and `t_states`=7.
- R8: Memory form is opcode 10ooo110. From the cycle after `start`, `mem_rd` is high with `mem_addr`={H,L}. `wr_en` pulses in the cycle after the clock edge that samples `mem_valid`, using `mem_data`, with `m_cycles`=2 and `t_states`=7.
- R9: Any other opcode gives an `unhandled` pulse one cycle after `start`. There is no `wr_en`, and `acc_out` and `flags_out` keep their previous values.
- R10: While `mem_rd` waits without `mem_valid`, the request stays high and `mem_addr` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the instruction on `opcode` (only while idle) |
| opcode | input | 8 | Instruction opcode |
| imm_in | input | 8 | Second instruction byte |
| acc_in | input | 8 | Current accumulator |
| regs_flat | input | 48 | Registers B,C,D,E,H,L, byte s at [8s+7:8s] |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address {H,L} |
| mem_valid | input | 1 | Memory data valid |
| mem_data | input | 8 | Memory read data |
| wr_en | output | 1 | Accumulator/flag write strobe (done) |
| acc_out | output | 8 | Result for the accumulator |
| flags_out | output | 5 | {sign, zero, aux, parity, carry} |
| m_cycles | output | 2 | Machine cycles of the finished instruction |
| t_states | output | 4 | Clock states of the finished instruction |
| unhandled | output | 1 | Pulse for an opcode outside the logical groups |

## Verification
All 256 opcodes are swept against four operand sets. This separates the three operations, the six operand sources and the unhandled codes from one another. One set drives an all-zero accumulator so that the zero flag and the AND aux rule meet results of 0x00. Others use bytes whose bit 3 differs between accumulator and operand, which separates the two aux variants; both variants are instantiated side by side. Memory reads return after zero, one and two wait cycles to show that the address holds steady and that completion follows `mem_valid` and not a fixed delay.

// File: rtl/lu_pkg.sv
package lu_pkg;
    localparam int W     = 8;
    localparam int NREG  = 6;
    localparam logic [2:0] SEL_MEM = 3'b110;
    localparam logic [2:0] SEL_ACC = 3'b111;

    typedef enum logic [1:0] {LOP_AND = 2'd0, LOP_XOR = 2'd1, LOP_OR = 2'd2} lop_e;
    typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_IMM, SRC_MEM} src_e;

    typedef struct packed {
        src_e       src;
        lop_e       op;
        logic [2:0] sel;
    } dec_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } flags_t;

    function automatic logic grp_ok(input logic [2:0] g);
        return (g == 3'b100) || (g == 3'b101) || (g == 3'b110);
    endfunction

    function automatic dec_t decode_op(input logic [7:0] opc);
        dec_t d;
        d.sel = opc[2:0];
        d.op  = lop_e'(opc[4:3]);
        d.src = SRC_NONE;
        if (grp_ok(opc[5:3])) begin
            if (opc[7:6] == 2'b10)
                d.src = (opc[2:0] == SEL_MEM) ? SRC_MEM : SRC_REG;
            else if (opc[7:6] == 2'b11 && opc[2:0] == SEL_MEM)
                d.src = SRC_IMM;
        end
        return d;
    endfunction

    function automatic logic even_ones(input logic [W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/lu_decode.sv
module lu_decode
    import lu_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb dec = decode_op(opcode);
endmodule

// File: rtl/lu_operand_mux.sv
module lu_operand_mux
    import lu_pkg::*;
(
    input  src_e                sel_src,
    input  logic [2:0]          sel,
    input  logic [W-1:0]        acc,
    input  logic [NREG*W-1:0]   regs_flat,
    input  logic [W-1:0]        imm,
    output logic [W-1:0]        operand
);
    logic [W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_split
        assign regs[i] = regs_flat[i*W +: W];
    end

    always_comb begin
        operand = '0;
        if (sel_src == SRC_IMM)
            operand = imm;
        else if (sel == SEL_ACC)
            operand = acc;
        else if (int'(sel) < NREG)
            operand = regs[sel];
    end
endmodule

// File: rtl/lu_alu.sv
module lu_alu
    import lu_pkg::*;
#(
    parameter bit AND_AC_BIT3 = 1'b1
) (
    input  lop_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output flags_t       flags
);
    logic and_aux;

    if (AND_AC_BIT3) begin : g_ac_bit3
        assign and_aux = a[3] | b[3];
    end else begin : g_ac_set
        assign and_aux = 1'b1;
    end

    always_comb begin
        unique case (op)
            LOP_AND: result = a & b;
            LOP_XOR: result = a ^ b;
            default: result = a | b;
        endcase
        flags.sign   = result[W-1];
        flags.zero   = (result == '0);
        flags.parity = even_ones(result);
        flags.carry  = 1'b0;
        flags.aux    = (op == LOP_AND) ? and_aux : 1'b0;
    end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import lu_pkg::*;
#(
    parameter bit AND_AC_BIT3 = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  imm_in,
    input  logic [7:0]  acc_in,
    input  logic [47:0] regs_flat,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic        mem_valid,
    input  logic [7:0]  mem_data,
    output logic        wr_en,
    output logic [7:0]  acc_out,
    output logic [4:0]  flags_out,
    output logic [1:0]  m_cycles,
    output logic [3:0]  t_states,
    output logic        unhandled
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    localparam int H_IDX = 4;
    localparam int L_IDX = 5;

    st_e          state;
    dec_t         dec;
    lop_e         lat_op;
    logic [W-1:0] lat_a;
    logic [15:0]  lat_addr;
    logic [W-1:0] mux_b;
    lop_e         alu_op;
    logic [W-1:0] alu_a, alu_b, alu_res;
    flags_t       alu_flags;

    lu_decode u_dec (.opcode(opcode), .dec(dec));

    lu_operand_mux u_mux (
        .sel_src  (dec.src),
        .sel      (dec.sel),
        .acc      (acc_in),
        .regs_flat(regs_flat),
        .imm      (imm_in),
        .operand  (mux_b)
    );

    always_comb begin
        if (state == ST_WAIT) begin
            alu_op = lat_op;
            alu_a  = lat_a;
            alu_b  = mem_data;
        end else begin
            alu_op = dec.op;
            alu_a  = acc_in;
            alu_b  = mux_b;
        end
    end

    lu_alu #(.AND_AC_BIT3(AND_AC_BIT3)) u_alu (
        .op    (alu_op),
        .a     (alu_a),
        .b     (alu_b),
        .result(alu_res),
        .flags (alu_flags)
    );

    assign mem_rd   = (state == ST_WAIT);
    assign mem_addr = lat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lat_op    <= LOP_AND;
            lat_a     <= '0;
            lat_addr  <= '0;
            wr_en     <= 1'b0;
            unhandled <= 1'b0;
            acc_out   <= '0;
            flags_out <= '0;
            m_cycles  <= '0;
            t_states  <= '0;
        end else begin
            wr_en     <= 1'b0;
            unhandled <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    unique case (dec.src)
                        SRC_NONE: unhandled <= 1'b1;
                        SRC_MEM: begin
                            state    <= ST_WAIT;
                            lat_op   <= dec.op;
                            lat_a    <= acc_in;
                            lat_addr <= {regs_flat[H_IDX*W +: W], regs_flat[L_IDX*W +: W]};
                        end
                        default: begin
                            wr_en     <= 1'b1;
                            acc_out   <= alu_res;
                            flags_out <= alu_flags;
                            m_cycles  <= (dec.src == SRC_IMM) ? 2'd2 : 2'd1;
                            t_states  <= (dec.src == SRC_IMM) ? 4'd7 : 4'd4;
                        end
                    endcase
                end
                default: if (mem_valid) begin
                    state     <= ST_IDLE;
                    wr_en     <= 1'b1;
                    acc_out   <= alu_res;
                    flags_out <= alu_flags;
                    m_cycles  <= 2'd2;
                    t_states  <= 4'd7;
                end
            endcase
        end
    end
endmodule

// File: rtl/lu_chk.sv
module lu_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [7:0]  opcode,
    input logic        mem_rd,
    input logic [15:0] mem_addr,
    input logic        mem_valid,
    input logic        wr_en,
    input logic [7:0]  acc_out,
    input logic [4:0]  flags_out,
    input logic [1:0]  m_cycles,
    input logic [3:0]  t_states,
    input logic        unhandled
);
    logic grp, reg_form;
    assign grp      = (opcode[5:3] == 3'b100) || (opcode[5:3] == 3'b101) || (opcode[5:3] == 3'b110);
    assign reg_form = grp && (opcode[7:6] == 2'b10) && (opcode[2:0] != 3'b110);

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (rst) !(wr_en && unhandled));
    // R3
    carry_clr_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> !flags_out[0]);
    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> flags_out[3] == (acc_out == 8'h00));
    // R2
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> flags_out[1] == ~^acc_out);
    // R2
    sign_flag_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> flags_out[4] == acc_out[7]);
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_valid) |=> (mem_rd && $stable(mem_addr)));
    // R6
    reg_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !mem_rd && reg_form) |=> (wr_en && m_cycles == 2'd1 && t_states == 4'd4));
    // R9
    unh_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !mem_rd && opcode == 8'h00) |=> (unhandled && !wr_en));
endmodule

bind acc_logic_unit lu_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .wr_en(wr_en), .acc_out(acc_out), .flags_out(flags_out),
    .m_cycles(m_cycles), .t_states(t_states), .unhandled(unhandled)
);

// File: tb/sim_acc_logic_unit.sv
module sim_acc_logic_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, imm_in = '0, acc_in = '0, mem_data = '0;
    logic [47:0] regs_flat = '0;
    logic        mem_valid = 1'b0;
    logic        mem_rd, wr_en, unhandled, mem_rd1, wr_en1, unh1;
    logic [15:0] mem_addr, mem_addr1;
    logic [7:0]  acc_out, acc_out1;
    logic [4:0]  flags_out, flags1;
    logic [1:0]  m_cycles, m1;
    logic [3:0]  t_states, t1;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    acc_logic_unit #(.AND_AC_BIT3(1'b1)) u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm_in(imm_in),
        .acc_in(acc_in), .regs_flat(regs_flat), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data), .wr_en(wr_en), .acc_out(acc_out),
        .flags_out(flags_out), .m_cycles(m_cycles), .t_states(t_states), .unhandled(unhandled)
    );

    acc_logic_unit #(.AND_AC_BIT3(1'b0)) u1 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm_in(imm_in),
        .acc_in(acc_in), .regs_flat(regs_flat), .mem_rd(mem_rd1), .mem_addr(mem_addr1),
        .mem_valid(mem_valid), .mem_data(mem_data), .wr_en(wr_en1), .acc_out(acc_out1),
        .flags_out(flags1), .m_cycles(m1), .t_states(t1), .unhandled(unh1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s op=%02h act=%0h exp=%0h", req, opcode, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_byte(input int s);
        return regs_flat[s*8 +: 8];
    endfunction

    task automatic run_one(input int wait_cyc);
        logic [2:0] g, s;
        logic [7:0] b, res, prev_acc;
        logic [4:0] prev_fl, exp_fl;
        bit ok_grp, is_mem, is_imm, is_reg;
        g = opcode[5:3];
        s = opcode[2:0];
        ok_grp = (g == 3'b100) || (g == 3'b101) || (g == 3'b110);
        is_mem = ok_grp && opcode[7:6] == 2'b10 && s == 3'b110;
        is_reg = ok_grp && opcode[7:6] == 2'b10 && s != 3'b110;
        is_imm = ok_grp && opcode[7:6] == 2'b11 && s == 3'b110;
        prev_acc = acc_out;
        prev_fl  = flags_out;
        if (is_imm)           b = imm_in;
        else if (is_mem)      b = mem_data;
        else if (s == 3'b111) b = acc_in;
        else                  b = reg_byte(int'(s));
        case (g)
            3'b100:  res = acc_in & b;
            3'b101:  res = acc_in ^ b;
            default: res = acc_in | b;
        endcase
        // R4 R5: aux rule; R3 carry always 0
        exp_fl = {res[7], res == 8'h00, (g == 3'b100) ? (acc_in[3] | b[3]) : 1'b0, ~^res, 1'b0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!(is_mem || is_reg || is_imm)) begin
            // R9: unhandled pulse, no write, outputs unchanged
            chk(unhandled && !wr_en, "R9", {unhandled, wr_en}, 2'b10);
            chk(acc_out == prev_acc && flags_out == prev_fl, "R9", {acc_out, flags_out}, {prev_acc, prev_fl});
            @(negedge clk);
            return;
        end
        if (is_mem) begin
            // R8: request with H:L address
            chk(mem_rd && !wr_en && mem_addr == {reg_byte(4), reg_byte(5)}, "R8", {mem_rd, mem_addr}, {1'b1, reg_byte(4), reg_byte(5)});
            for (int k = 0; k < wait_cyc; k++) begin
                @(negedge clk);
                // R10: request held, address stable
                chk(mem_rd && !wr_en && mem_addr == {reg_byte(4), reg_byte(5)}, "R10", {mem_rd, mem_addr}, {1'b1, reg_byte(4), reg_byte(5)});
            end
            mem_valid = 1'b1;
            @(negedge clk);
            mem_valid = 1'b0;
        end
        // R1 result, R6/R7/R8 timing and cost
        chk(wr_en && !unhandled, is_mem ? "R8" : (is_imm ? "R7" : "R6"), wr_en, 1);
        chk(acc_out == res, "R1", acc_out, res);
        chk(flags_out == exp_fl, "R2", flags_out, exp_fl);
        chk(flags_out[0] == 1'b0, "R3", flags_out[0], 0);
        chk(m_cycles == (is_reg ? 2'd1 : 2'd2) && t_states == (is_reg ? 4'd4 : 4'd7),
            is_reg ? "R6" : "R7", {m_cycles, t_states}, is_reg ? {2'd1, 4'd4} : {2'd2, 4'd7});
        // R4 forced-set variant, R5 cleared for XOR/OR
        chk(flags1[2] == (g == 3'b100), g == 3'b100 ? "R4" : "R5", flags1[2], g == 3'b100);
        chk(acc_out1 == res, "R1", acc_out1, res);
        @(negedge clk);
        chk(!wr_en && !mem_rd, "R8", {wr_en, mem_rd}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !mem_rd && !unhandled && acc_out == 8'h00 && flags_out == 5'h00, "R9",
            {wr_en, mem_rd, unhandled, acc_out, flags_out}, 0);
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 256; op++) begin
                opcode    = op[7:0];
                acc_in    = (p == 0) ? 8'h00 : 8'(8'h5A ^ (p * 8'h37) ^ op[7:0]);
                imm_in    = 8'(8'hC3 + p * 8'h29 + op[7:0]);
                mem_data  = 8'(8'h18 ^ (p * 8'h6D) ^ {op[3:0], op[7:4]});
                for (int r = 0; r < 6; r++)
                    regs_flat[r*8 +: 8] = 8'(r * 8'h1F + p * 8'h53 + op[6:0]);
                run_one((op + p) % 3);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule